// File: doc/BRIEF.md
# Pipelined Top-Four Selector and Sorter

This block accepts eight unsigned values every clock cycle and returns the four largest of them in descending order. Each output carries the lane number (0 to 7) where the value entered, so downstream logic can fetch any payload tied to that lane. A valid flag moves through the pipeline in step with the data. Input lanes that are not valid in a given cycle are not masked per lane: the whole set is tagged by the single input valid bit.

The datapath is a fixed compare-and-exchange network split into six registered stages. A parameter selects one of two networks. The bitonic form sorts each half of the inputs, in opposite directions, keeps the larger member of four cross pairs, then sorts those four survivors with a small bitonic merge. This uses 20 comparators. The odd-even form is a full eight-input odd-even merge sort with the one comparator that only touches the discarded lower half removed. This uses 18 comparators. Both forms give identical results for every input.

Top module: `topk_sorter`

## Requirements
- R1: When `vld_o` is high, `val_o[0]` through `val_o[3]` are the four largest of the eight values sampled six cycles earlier, ordered so that `val_o[k] >= val_o[k+1]`.
- R2: Values that are equal are ranked by input lane: the lower lane number ranks higher, both when choosing which four survive and when ordering them.
- R3: `idx_o[k]` is the input lane (0 to 7, lane `j` being `val_i[j]`) from which `val_o[k]` came.
- R4: `vld_o` equals `vld_i` delayed by exactly six rising clock edges, and the data are aligned with it.
- R5: A new eight-value set is accepted on every cycle with no bubbles, and sets separated by idle cycles are handled the same way as back-to-back sets.
- R6: The bitonic topology (`TOPO` = 0) and the odd-even topology (`TOPO` = 1) produce identical `vld_o`, `val_o` and `idx_o` for identical inputs.
- R7: While `rst_ni` is low, and after it rises until the first valid set has reached the output, `vld_o` is 0.
- R8: When `vld_o` is high, the four `idx_o` values are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | The eight input values are valid this cycle |
| val_i | input | 8 x DATA_W | Eight unsigned input values, lane `j` at `val_i[j]` |
| vld_o | output | 1 | The output values are valid |
| val_o | output | 4 x DATA_W | Four largest values, `val_o[0]` is the largest |
| idx_o | output | 4 x 3 | Input lane of each output value |

## Verification
Every result of this block falls due exactly six rising edges after the inputs that produced it are sampled, one stage per edge. The bench drives inputs on the falling edge and keeps a six-deep queue of what it drove. On each falling edge it pops the set driven six cycles before and compares it with both topologies' outputs, which registered the result at the rising edge just passed. Idle and reset cycles go into the same queue, so a valid flag that arrives one cycle early or late causes a mismatch on the exact cycle it appears.

// File: rtl/topk_pkg.sv
package topk_pkg;

  localparam int NUM_IN  = 8;
  localparam int NUM_OUT = 4;
  localparam int IDX_W   = 3;
  localparam int NUM_STG = 6;
  localparam int MAX_CAE = 4;

  typedef enum logic {
    TOPO_BITONIC = 1'b0,
    TOPO_ODDEVEN = 1'b1
  } topo_e;

  // {present, upper lane (gets the winner), lower lane (gets the loser)}
  function automatic logic [6:0] mk_pair(int h, int l);
    return {1'b1, 3'(h), 3'(l)};
  endfunction

  function automatic logic [6:0] cae_pair(topo_e t, int s, int k);
    logic [6:0] p [MAX_CAE];
    for (int i = 0; i < MAX_CAE; i++) p[i] = '0;
    if (t == TOPO_BITONIC) begin
      case (s)
        1: begin p[0] = mk_pair(0,1); p[1] = mk_pair(3,2); p[2] = mk_pair(4,5); p[3] = mk_pair(7,6); end
        2: begin p[0] = mk_pair(0,2); p[1] = mk_pair(1,3); p[2] = mk_pair(6,4); p[3] = mk_pair(7,5); end
        3: begin p[0] = mk_pair(0,1); p[1] = mk_pair(2,3); p[2] = mk_pair(5,4); p[3] = mk_pair(7,6); end
        4: begin p[0] = mk_pair(0,4); p[1] = mk_pair(1,5); p[2] = mk_pair(2,6); p[3] = mk_pair(3,7); end
        5: begin p[0] = mk_pair(0,2); p[1] = mk_pair(1,3); end
        6: begin p[0] = mk_pair(0,1); p[1] = mk_pair(2,3); end
        default: ;
      endcase
    end else begin
      case (s)
        1: begin p[0] = mk_pair(0,1); p[1] = mk_pair(2,3); p[2] = mk_pair(4,5); p[3] = mk_pair(6,7); end
        2: begin p[0] = mk_pair(0,2); p[1] = mk_pair(1,3); p[2] = mk_pair(4,6); p[3] = mk_pair(5,7); end
        3: begin p[0] = mk_pair(1,2); p[1] = mk_pair(5,6); end
        4: begin p[0] = mk_pair(0,4); p[1] = mk_pair(1,5); p[2] = mk_pair(2,6); p[3] = mk_pair(3,7); end
        5: begin p[0] = mk_pair(2,4); p[1] = mk_pair(3,5); end
        6: begin p[0] = mk_pair(1,2); p[1] = mk_pair(3,4); end
        default: ;
      endcase
    end
    return p[k[1:0]];
  endfunction

  // {has partner, is upper lane, partner lane}
  function automatic logic [4:0] lane_map(topo_e t, int s, int j);
    logic [4:0] r;
    logic [6:0] e;
    r = '0;
    for (int k = 0; k < MAX_CAE; k++) begin
      e = cae_pair(t, s, k);
      if (e[6] && e[5:3] == 3'(j))      r = {2'b11, e[2:0]};
      else if (e[6] && e[2:0] == 3'(j)) r = {2'b10, e[5:3]};
    end
    return r;
  endfunction

  // lanes still live after stage s (s = 0 is the input)
  function automatic int stage_lanes(topo_e t, int s);
    if (s <= 3) return NUM_IN;
    if (t == TOPO_BITONIC) return NUM_OUT;
    case (s)
      4:       return 6;
      5:       return 5;
      default: return NUM_OUT;
    endcase
  endfunction

endpackage

// File: rtl/topk_stage.sv
module topk_stage
  import topk_pkg::*;
#(
  parameter int    DATA_W = 10,
  parameter topo_e TOPO   = TOPO_BITONIC,
  parameter int    STG    = 1,
  localparam int   EW     = DATA_W + IDX_W,
  localparam int   N_IN   = stage_lanes(TOPO, STG - 1),
  localparam int   N_OUT  = stage_lanes(TOPO, STG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [N_IN*EW-1:0]  dat_i,
  output logic              vld_o,
  output logic [N_OUT*EW-1:0] dat_o
);

  typedef logic [EW-1:0] elem_t;

  elem_t in_a [N_IN];
  elem_t nxt  [N_OUT];
  elem_t q    [N_OUT];
  logic  vld_q;

  function automatic logic ranks_above(elem_t a, elem_t b);
    return (a[EW-1:IDX_W] > b[EW-1:IDX_W]) ||
           ((a[EW-1:IDX_W] == b[EW-1:IDX_W]) && (a[IDX_W-1:0] < b[IDX_W-1:0]));
  endfunction

  always_comb begin
    for (int j = 0; j < N_IN; j++) in_a[j] = dat_i[j*EW +: EW];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_lane
    localparam logic [4:0] MAP = lane_map(TOPO, STG, j);
    if (!MAP[4]) begin : g_pass
      assign nxt[j] = in_a[j];
    end else begin : g_cae
      localparam int P = int'(MAP[2:0]);
      localparam int H = MAP[3] ? j : P;
      localparam int L = MAP[3] ? P : j;
      logic up_wins;
      // both lanes of a pair evaluate the same expression, so it is shared
      assign up_wins = ranks_above(in_a[H], in_a[L]);
      if (MAP[3]) begin : g_hi
        assign nxt[j] = up_wins ? in_a[H] : in_a[L];
      end else begin : g_lo
        assign nxt[j] = up_wins ? in_a[L] : in_a[H];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      for (int j = 0; j < N_OUT; j++) q[j] <= '0;
    end else begin
      vld_q <= vld_i;
      for (int j = 0; j < N_OUT; j++) q[j] <= nxt[j];
    end
  end

  always_comb begin
    for (int j = 0; j < N_OUT; j++) dat_o[j*EW +: EW] = q[j];
  end
  assign vld_o = vld_q;

  AST_STAGE_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (vld_o == $past(vld_i))); // R4

endmodule

// File: rtl/topk_net.sv
module topk_net
  import topk_pkg::*;
#(
  parameter int    DATA_W = 10,
  parameter topo_e TOPO   = TOPO_BITONIC,
  localparam int   EW     = DATA_W + IDX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic [NUM_IN*EW-1:0]  dat_i,
  output logic                  vld_o,
  output logic [NUM_OUT*EW-1:0] dat_o
);

  for (genvar s = 1; s <= NUM_STG; s++) begin : g_stg
    localparam int NI = stage_lanes(TOPO, s - 1);
    localparam int NO = stage_lanes(TOPO, s);
    logic             src_vld;
    logic [NI*EW-1:0] src_dat;
    logic             vld;
    logic [NO*EW-1:0] dat;

    if (s == 1) begin : g_head
      assign src_vld = vld_i;
      assign src_dat = dat_i;
    end else begin : g_link
      assign src_vld = g_stg[s-1].vld;
      assign src_dat = g_stg[s-1].dat;
    end

    topk_stage #(
      .DATA_W (DATA_W),
      .TOPO   (TOPO),
      .STG    (s)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (src_vld),
      .dat_i  (src_dat),
      .vld_o  (vld),
      .dat_o  (dat)
    );
  end

  assign vld_o = g_stg[NUM_STG].vld;
  assign dat_o = g_stg[NUM_STG].dat;

endmodule

// File: rtl/topk_sorter.sv
module topk_sorter
  import topk_pkg::*;
#(
  parameter int    DATA_W = 10,
  parameter topo_e TOPO   = TOPO_BITONIC
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             vld_i,
  input  logic [NUM_IN-1:0][DATA_W-1:0]    val_i,
  output logic                             vld_o,
  output logic [NUM_OUT-1:0][DATA_W-1:0]   val_o,
  output logic [NUM_OUT-1:0][IDX_W-1:0]    idx_o
);

  localparam int EW = DATA_W + IDX_W;

  logic [NUM_IN*EW-1:0]  dat_in;
  logic [NUM_OUT*EW-1:0] dat_out;

  for (genvar j = 0; j < NUM_IN; j++) begin : g_tag
    assign dat_in[j*EW +: EW] = {val_i[j], IDX_W'(j)};
  end

  topk_net #(
    .DATA_W (DATA_W),
    .TOPO   (TOPO)
  ) u_net (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_i),
    .dat_i  (dat_in),
    .vld_o  (vld_o),
    .dat_o  (dat_out)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    assign val_o[k] = dat_out[k*EW+IDX_W +: DATA_W];
    assign idx_o[k] = dat_out[k*EW +: IDX_W];
  end

  logic [NUM_IN-1:0] idx_mask;
  always_comb begin
    idx_mask = '0;
    for (int k = 0; k < NUM_OUT; k++) idx_mask[idx_o[k]] = 1'b1;
  end

  for (genvar k = 0; k < NUM_OUT - 1; k++) begin : g_chk
    AST_DESC_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> (val_o[k] >= val_o[k+1])); // R1
    AST_TIE_LOW_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o && (val_o[k] == val_o[k+1])) |-> (idx_o[k] < idx_o[k+1])); // R2
  end

  AST_IDX_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ($countones(idx_mask) == NUM_OUT)); // R8

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !vld_o); // R7

endmodule

// File: tb/topk_sorter_tb.sv
`timescale 1ns/1ps
module topk_sorter_tb;
  import topk_pkg::*;

  localparam int DW  = 10;
  localparam int LAT = NUM_STG;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic vld_i = 1'b0;
  logic [NUM_IN-1:0][DW-1:0] val_i = '0;

  logic                        vld_a, vld_b;
  logic [NUM_OUT-1:0][DW-1:0]  val_a, val_b;
  logic [NUM_OUT-1:0][IDX_W-1:0] idx_a, idx_b;

  always #2.5 clk_i = ~clk_i;

  topk_sorter #(.DATA_W(DW), .TOPO(TOPO_BITONIC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .val_i(val_i),
    .vld_o(vld_a), .val_o(val_a), .idx_o(idx_a));

  topk_sorter #(.DATA_W(DW), .TOPO(TOPO_ODDEVEN)) u_dut_oe (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .val_i(val_i),
    .vld_o(vld_b), .val_o(val_b), .idx_o(idx_b));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit                     vq[$];
  logic [NUM_IN*DW-1:0]   dq[$];

  task automatic chk(string req, string what, bit ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [NUM_IN*DW-1:0] d,
                       output logic [NUM_OUT-1:0][DW-1:0] ev,
                       output logic [NUM_OUT-1:0][IDX_W-1:0] ei);
    int v[NUM_IN];
    bit used[NUM_IN];
    for (int i = 0; i < NUM_IN; i++) begin
      v[i] = int'(d[i*DW +: DW]);
      used[i] = 0;
    end
    for (int p = 0; p < NUM_OUT; p++) begin
      int best = -1;
      for (int i = 0; i < NUM_IN; i++)
        if (!used[i] && (best < 0 || v[i] > v[best])) best = i;
      used[best] = 1;
      ev[p] = DW'(v[best]);
      ei[p] = IDX_W'(best);
    end
  endtask

  task automatic check_cycle(string req);
    bit ev_v = 0;
    logic [NUM_IN*DW-1:0] d = '0;
    logic [NUM_OUT-1:0][DW-1:0] ev;
    logic [NUM_OUT-1:0][IDX_W-1:0] ei;
    if (vq.size() == LAT) begin
      ev_v = vq.pop_front();
      d = dq.pop_front();
    end
    model(d, ev, ei);
    chk("R4", "vld_o bitonic", vld_a == ev_v, 64'(vld_a), 64'(ev_v));
    chk("R4", "vld_o odd-even", vld_b == ev_v, 64'(vld_b), 64'(ev_v));
    if (ev_v) begin
      chk(req, "values/index bitonic", {val_a, idx_a} == {ev, ei},
          64'({val_a, idx_a}), 64'({ev, ei}));
      chk(req, "values/index odd-even", {val_b, idx_b} == {ev, ei},
          64'({val_b, idx_b}), 64'({ev, ei}));
    end
    chk("R6", "topologies agree", {vld_a, val_a, idx_a} == {vld_b, val_b, idx_b},
        64'({vld_b, val_b, idx_b}), 64'({vld_a, val_a, idx_a}));
  endtask

  task automatic step(string req, bit v, logic [NUM_IN-1:0][DW-1:0] dv);
    @(negedge clk_i);
    check_cycle(req);
    vld_i = v;
    val_i = dv;
    vq.push_back(v);
    dq.push_back(dv);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [NUM_IN-1:0][DW-1:0] d;
    // R7: reset holds vld_o low
    for (int c = 0; c < 4; c++) step("R7", 1'b0, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    vq.delete();
    dq.delete();
    for (int c = 0; c < 3; c++) step("R7", 1'b0, '0);

    // R4: isolated valid set, exact latency
    for (int j = 0; j < NUM_IN; j++) d[j] = DW'(37 * j + 5);
    step("R4", 1'b1, d);
    for (int c = 0; c < 8; c++) step("R4", 1'b0, '0);

    // R1 R3: random back-to-back sets
    for (int c = 0; c < 300; c++) begin
      for (int j = 0; j < NUM_IN; j++) d[j] = DW'($urandom);
      step("R1/R3", 1'b1, d);
    end

    // R2 R8: duplicate-heavy values
    for (int c = 0; c < 200; c++) begin
      for (int j = 0; j < NUM_IN; j++) d[j] = DW'($urandom % 4);
      step("R2/R8", 1'b1, d);
    end
    for (int j = 0; j < NUM_IN; j++) d[j] = DW'(512);
    step("R2", 1'b1, d);
    for (int j = 0; j < NUM_IN; j++) d[j] = '0;
    step("R2", 1'b1, d);

    // R1: already sorted both ways, extremes
    for (int j = 0; j < NUM_IN; j++) d[j] = DW'(100 * j);
    step("R1", 1'b1, d);
    for (int j = 0; j < NUM_IN; j++) d[j] = DW'(100 * (NUM_IN - 1 - j));
    step("R1", 1'b1, d);
    for (int j = 0; j < NUM_IN; j++) d[j] = (j % 2 == 1) ? '1 : '0;
    step("R1", 1'b1, d);
    for (int j = 0; j < NUM_IN; j++) d[j] = (j == NUM_IN - 1) ? '1 : DW'(1);
    step("R1", 1'b1, d);

    // R5: random gaps between sets
    for (int c = 0; c < 150; c++) begin
      for (int j = 0; j < NUM_IN; j++) d[j] = DW'($urandom % 16);
      step("R5", 1'($urandom % 2), d);
    end

    for (int c = 0; c < LAT + 2; c++) step("R4", 1'b0, '0);
    finish_run();
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule